// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Relative Branching

This block holds the program counter of a 16-bit processor whose instructions are each two bytes long. On every clock edge where stepping is enabled, it picks one of three next addresses. The first is the following instruction. The second is a relative branch target, used when a 3-bit condition is met by the current status flags. The third is an absolute address taken from a register operand. The status flags (zero, negative, overflow) come from an external arithmetic unit. Instruction fetch and decode also sit outside this block.

The decoder drives an operation selector, the condition code, a signed 8-bit displacement counted in instructions, and the register value used for jumps. A branch displacement is sign-extended and multiplied by the instruction size before it is added to the current address. Signed ordering is derived from the flags, so greater-than and less-than treat the compared values as two's-complement numbers.

Top module: `pc_flow_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x0000 at the next clock edge, whatever the other inputs are.
- R2: While step_en is 0 and reset is inactive, the program counter keeps its value, whatever the operation, flags, displacement or jump address.
- R3: With step_en high and pc_op equal to 2'b00 (advance) or 2'b11 (spare, behaves as advance), the program counter increases by 2, wrapping modulo 2^16.
- R4: With step_en high and pc_op equal to 2'b10 (jump), the program counter takes the value of jump_addr unchanged.
- R5: With step_en high and pc_op equal to 2'b01 (branch), a met condition loads the current program counter plus the sign-extended br_offset times 2, wrapping modulo 2^16.
- R6: Condition 3'b000 (equal) is met exactly when flag_zero is 1. Condition 3'b001 (not equal) is met exactly when flag_zero is 0.
- R7: Condition 3'b010 (signed greater) is met when flag_zero is 0 and flag_neg equals flag_ovf. Condition 3'b011 (signed greater or equal) is met when flag_neg equals flag_ovf.
- R8: Condition 3'b100 (signed less) is met when flag_neg differs from flag_ovf. Condition 3'b101 (signed less or equal) is met when flag_zero is 1 or flag_neg differs from flag_ovf.
- R9: Condition 3'b111 is met regardless of the flags. Reserved condition 3'b110 is never met.
- R10: A branch whose condition is not met advances the program counter by 2, as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Allows the program counter to move this cycle |
| pc_op | input | 2 | 00 advance, 01 branch, 10 jump, 11 advance |
| br_cond | input | 3 | Branch condition code |
| flag_zero | input | 1 | Zero status flag |
| flag_neg | input | 1 | Negative status flag |
| flag_ovf | input | 1 | Signed overflow status flag |
| br_offset | input | 8 | Signed branch displacement in instructions |
| jump_addr | input | 16 | Absolute target for a jump |
| pc | output | 16 | Current program counter |

## Verification
The hardest cases to reach are the signed conditions where the overflow flag flips the meaning of the negative flag. For example, a most-negative operand compared against a positive one gives a positive difference with overflow set. The bench does not drive flag patterns by hand. It builds the flags from real pairs of signed operands, including ones at the extremes of the 16-bit range. It then predicts the branch decision from an ordinary signed comparison of those operands. Address wrap-around is reached by jumping near the top of the address space and branching backward from address zero.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        PC_OP_NEXT   = 2'b00,
        PC_OP_BRANCH = 2'b01,
        PC_OP_JUMP   = 2'b10,
        PC_OP_SPARE  = 2'b11
    } pc_op_e;

    typedef enum logic [2:0] {
        COND_EQ     = 3'b000,
        COND_NE     = 3'b001,
        COND_GT     = 3'b010,
        COND_GE     = 3'b011,
        COND_LT     = 3'b100,
        COND_LE     = 3'b101,
        COND_RSVD   = 3'b110,
        COND_ALWAYS = 3'b111
    } cond_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

    // Signed "less than" is signalled by negative differing from overflow.
    function automatic logic cond_met(cond_e c, flags_t f);
        logic below;
        logic res;
        below = f.neg ^ f.ovf;
        case (c)
            COND_EQ:     res = f.zero;
            COND_NE:     res = ~f.zero;
            COND_GT:     res = ~f.zero & ~below;
            COND_GE:     res = ~below;
            COND_LT:     res = below;
            COND_LE:     res = f.zero | below;
            COND_ALWAYS: res = 1'b1;
            default:     res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  logic [2:0] cond,
    input  flags_t     flags,
    output logic       taken
);

    always_comb begin
        taken = cond_met(cond_e'(cond), flags);
    end

endmodule

// File: rtl/pcu_next_calc.sv
module pcu_next_calc
    import pcu_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFS_W      = 8,
    parameter int STEP_BYTES = 2
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [1:0]        op,
    input  logic              taken,
    input  logic [OFS_W-1:0]  offset,
    input  logic [ADDR_W-1:0] jump_target,
    output logic [ADDR_W-1:0] next_pc
);

    localparam int SHIFT = $clog2(STEP_BYTES);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_addr;

    assign ofs_ext  = {{EXT_W{offset[OFS_W-1]}}, offset};
    assign seq_addr = cur_pc + ADDR_W'(STEP_BYTES);
    assign rel_addr = cur_pc + (ofs_ext << SHIFT);

    always_comb begin
        case (pc_op_e'(op))
            PC_OP_BRANCH: next_pc = taken ? rel_addr : seq_addr;
            PC_OP_JUMP:   next_pc = jump_target;
            default:      next_pc = seq_addr;
        endcase
    end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFS_W      = 8,
    parameter int STEP_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [1:0]        pc_op,
    input  logic [2:0]        br_cond,
    input  logic              flag_zero,
    input  logic              flag_neg,
    input  logic              flag_ovf,
    input  logic [OFS_W-1:0]  br_offset,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic [ADDR_W-1:0] pc
);

    flags_t            flags;
    logic              taken;
    logic [ADDR_W-1:0] next_pc;

    assign flags = '{zero: flag_zero, neg: flag_neg, ovf: flag_ovf};

    pcu_cond_eval u_cond (
        .cond  (br_cond),
        .flags (flags),
        .taken (taken)
    );

    pcu_next_calc #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_next (
        .cur_pc      (pc),
        .op          (pc_op),
        .taken       (taken),
        .offset      (br_offset),
        .jump_target (jump_addr),
        .next_pc     (next_pc)
    );

    pcu_pc_reg #(
        .ADDR_W (ADDR_W)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .d   (next_pc),
        .q   (pc)
    );

endmodule

// File: rtl/pc_flow_unit_chk.sv
module pc_flow_unit_chk #(
    parameter int ADDR_W     = 16,
    parameter int OFS_W      = 8,
    parameter int STEP_BYTES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [1:0]        pc_op,
    input logic [2:0]        br_cond,
    input logic              flag_zero,
    input logic              flag_neg,
    input logic              flag_ovf,
    input logic [OFS_W-1:0]  br_offset,
    input logic [ADDR_W-1:0] jump_addr,
    input logic [ADDR_W-1:0] pc
);

    logic [ADDR_W-1:0] disp_bytes;
    assign disp_bytes = ADDR_W'($signed(br_offset)) * ADDR_W'(STEP_BYTES);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> pc == '0);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> pc == $past(pc));

    // R3
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && (pc_op == 2'b00 || pc_op == 2'b11)) |=> pc == $past(pc) + ADDR_W'(STEP_BYTES));

    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_op == 2'b10) |=> pc == $past(jump_addr));

    // R5
    always_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_op == 2'b01 && br_cond == 3'b111) |=> pc == $past(pc) + $past(disp_bytes));

    // R9
    reserved_never_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_op == 2'b01 && br_cond == 3'b110) |=> pc == $past(pc) + ADDR_W'(STEP_BYTES));

    // R6
    eq_untaken_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_op == 2'b01 && br_cond == 3'b000 && !flag_zero) |=> pc == $past(pc) + ADDR_W'(STEP_BYTES));

    // R8
    lt_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_op == 2'b01 && br_cond == 3'b100 && (flag_neg != flag_ovf)) |=> pc == $past(pc) + $past(disp_bytes));

endmodule

bind pc_flow_unit pc_flow_unit_chk #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .STEP_BYTES (STEP_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .pc_op     (pc_op),
    .br_cond   (br_cond),
    .flag_zero (flag_zero),
    .flag_neg  (flag_neg),
    .flag_ovf  (flag_ovf),
    .br_offset (br_offset),
    .jump_addr (jump_addr),
    .pc        (pc)
);

// File: tb/pc_flow_unit_test.sv
`timescale 1ns/1ps
module pc_flow_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [1:0]  pc_op = 2'b00;
    logic [2:0]  br_cond = 3'b000;
    logic        flag_zero = 1'b0;
    logic        flag_neg = 1'b0;
    logic        flag_ovf = 1'b0;
    logic [7:0]  br_offset = 8'h00;
    logic [15:0] jump_addr = 16'h0000;
    logic [15:0] pc;

    int checks = 0;
    int fails = 0;
    int model_pc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_flow_unit uut (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .pc_op     (pc_op),
        .br_cond   (br_cond),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .flag_ovf  (flag_ovf),
        .br_offset (br_offset),
        .jump_addr (jump_addr),
        .pc        (pc)
    );

    function automatic int seq_of(int p);
        return (p + 2) & 'hFFFF;
    endfunction

    function automatic int rel_of(int p, logic [7:0] of);
        return (p + 2 * int'($signed(of))) & 'hFFFF;
    endfunction

    // Drive at the falling edge, check one time step after the next rising edge.
    task automatic cyc(input bit r, input bit en, input logic [1:0] o, input logic [2:0] c,
                       input bit z, input bit n, input bit v, input logic [7:0] of,
                       input logic [15:0] ja, input int expv, input string tag);
        rst = r; step_en = en; pc_op = o; br_cond = c;
        flag_zero = z; flag_neg = n; flag_ovf = v;
        br_offset = of; jump_addr = ja;
        @(posedge clk);
        #1;
        checks++;
        if (pc !== expv[15:0]) begin
            fails++;
            $display("FAIL %s: pc=%h expected %h", tag, pc, expv[15:0]);
        end
        model_pc = expv;
        @(negedge clk);
    endtask

    // Flags from a real signed subtraction a - b; decision from a signed compare.
    task automatic branch_case(input int a, input int b, input logic [2:0] c, input logic [7:0] of);
        logic [15:0] ua, ub, d;
        bit z, n, v, tk;
        string tag;
        ua = a[15:0]; ub = b[15:0]; d = ua - ub;
        z = (d == 16'h0000);
        n = d[15];
        v = (ua[15] != ub[15]) && (d[15] != ua[15]);
        case (c)
            3'd0: tk = (a == b);
            3'd1: tk = (a != b);
            3'd2: tk = (a > b);
            3'd3: tk = (a >= b);
            3'd4: tk = (a < b);
            3'd5: tk = (a <= b);
            3'd6: tk = 1'b0;
            default: tk = 1'b1;
        endcase
        case (c)
            3'd0, 3'd1: tag = tk ? "R6 R5" : "R6 R10";
            3'd2, 3'd3: tag = tk ? "R7 R5" : "R7 R10";
            3'd4, 3'd5: tag = tk ? "R8 R5" : "R8 R10";
            default:    tag = tk ? "R9 R5" : "R9 R10";
        endcase
        cyc(1'b0, 1'b1, 2'b01, c, z, n, v, of, 16'hDEAD,
            tk ? rel_of(model_pc, of) : seq_of(model_pc), tag);
    endtask

    initial begin
        int pa [8] = '{5, 3, 9, -32768, 100, -5, 32767, -1};
        int pb [8] = '{5, 9, 3, 1, -100, -5, -1, 32767};
        logic [7:0] offs [4] = '{8'h7F, 8'h80, 8'hFE, 8'h04};

        @(negedge clk);
        // R1: reset state
        cyc(1'b1, 1'b1, 2'b10, 3'b111, 1'b1, 1'b1, 1'b1, 8'h55, 16'h1234, 0, "R1");
        cyc(1'b1, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 0, "R1");

        // R3: advance, including the spare code
        cyc(1'b0, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, seq_of(model_pc), "R3");
        cyc(1'b0, 1'b1, 2'b00, 3'b111, 1'b1, 1'b0, 1'b0, 8'h10, 16'hAAAA, seq_of(model_pc), "R3");
        cyc(1'b0, 1'b1, 2'b11, 3'b111, 1'b1, 1'b1, 1'b0, 8'h10, 16'hAAAA, seq_of(model_pc), "R3");

        // R2: idle cycles ignore every other input
        cyc(1'b0, 1'b0, 2'b10, 3'b111, 1'b1, 1'b1, 1'b1, 8'h7F, 16'hBEEF, model_pc, "R2");
        cyc(1'b0, 1'b0, 2'b01, 3'b111, 1'b0, 1'b0, 1'b0, 8'h80, 16'h0000, model_pc, "R2");
        cyc(1'b0, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, model_pc, "R2");

        // R4: jump, then advance across the top of the address space
        cyc(1'b0, 1'b1, 2'b10, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'hFFFE, 'hFFFE, "R4");
        cyc(1'b0, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, seq_of(model_pc), "R3 wrap");
        // R5: backward branch from zero wraps
        cyc(1'b0, 1'b1, 2'b01, 3'b111, 1'b0, 1'b0, 1'b0, 8'hFF, 16'h0000, rel_of(model_pc, 8'hFF), "R5 wrap");
        cyc(1'b0, 1'b1, 2'b10, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h4000, 'h4000, "R4");

        // R6..R10: every condition against several operand pairs and displacements
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 8; c++) begin
                branch_case(pa[i], pb[i], 3'(c), offs[(i + c) % 4]);
            end
        end

        // R9: always ignores flags in every combination; reserved never moves by offset
        for (int f = 0; f < 8; f++) begin
            cyc(1'b0, 1'b1, 2'b01, 3'b111, f[2], f[1], f[0], 8'h08, 16'h0000, rel_of(model_pc, 8'h08), "R9 R5");
            cyc(1'b0, 1'b1, 2'b01, 3'b110, f[2], f[1], f[0], 8'h08, 16'h0000, seq_of(model_pc), "R9 R10");
        end

        // R1: reset in the middle of a run
        cyc(1'b1, 1'b1, 2'b10, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h7777, 0, "R1");
        cyc(1'b0, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, seq_of(model_pc), "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): pc=%h expected run completion", pc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule